// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive byte path of an Ethernet MAC. It looks at the first six bytes of each incoming frame, which carry the destination address, and decides whether the frame should be kept. The frame store uses this decision to write accepted frames to receive memory and to drop every other frame.

Bytes arrive one per cycle while `byte_vld` is high. Gaps of any length may appear between bytes. The first byte of each frame is flagged with `sof`. The decision combines four checks, and a frame is accepted when any enabled check passes:

- an exact compare against a programmed 48-bit station address;
- a hashed lookup into a 64-bit multicast table;
- a broadcast enable;
- a promiscuous enable.

The result appears one clock after the sixth destination byte, together with a one-cycle strobe. It stays on the output until the next frame starts.

Top module: `da_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `accept` and `decision_vld` are 0. After reset, bytes are ignored until a byte arrives with `sof` set.
- R2: `decision_vld` is high for exactly one cycle per frame: the cycle after the sixth header byte is taken. The header count starts at the byte carrying `sof` as byte 0.
- R3: Destination byte i (the i-th header byte) is compared with `station_addr[8*i+7:8*i]`. When all six bytes are equal, the frame is accepted.
- R4: A destination made of all ones is a broadcast. It is accepted when `cfg_bcast_en` is 1 and is never treated as a multicast.
- R5: A destination with bit 0 of byte 0 set that is not all ones is a multicast. It is accepted when `cfg_mcast_en` is 1 and `mcast_table[idx]` is 1. Table byte r is `mcast_table[8*r+7:8*r]`, so idx[5:3] selects the byte and idx[2:0] selects the bit within it.
- R6: The hash index idx is computed with a 32-bit register in four steps:
  - The register starts at FFFFFFFFh.
  - For each of the six destination bytes in order, and each bit from bit 0 to bit 7, the feedback is reg[31] XOR the data bit.
  - The register then shifts left by one, and 04C11DB7h is XORed in when the feedback is 1.
  - idx is reg[31:26], with no final inversion.
- R7: When `cfg_promisc` is 1, every frame is accepted.
- R8: A frame that passes none of the checks in R3, R4, R5 and R7 gives `accept` = 0 with the strobe.
- R9: `accept` holds its value from the strobe until the next `sof` byte. On that byte it clears to 0.
- R10: Bytes after the sixth header byte, and bytes arriving after reset before any `sof`, do not change `accept` and do not produce a strobe. Idle cycles inside the header do not disturb the count.
- R11: A `sof` byte arriving part-way through a header restarts the count and the hash from byte 0.
- R12: The configuration bits and tables are used as they stand in the cycle the sixth byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A byte is present on `byte_data` |
| sof | input | 1 | Marks the first byte of a frame (qualified by `byte_vld`) |
| byte_data | input | 8 | Received frame byte |
| station_addr | input | 48 | Station address, header byte i in bits 8i+7:8i |
| mcast_table | input | 64 | Multicast hash table, indexed by the 6-bit hash |
| cfg_bcast_en | input | 1 | Accept broadcast destinations |
| cfg_mcast_en | input | 1 | Enable multicast hash lookup |
| cfg_promisc | input | 1 | Accept every destination |
| accept | output | 1 | Decision for the current frame, held until next `sof` |
| decision_vld | output | 1 | One-cycle strobe when `accept` is updated |

## Verification
The bench builds the block with its default parameters: a six-byte header and a 6-bit hash into a 64-entry table. These are the widths a real Ethernet receiver uses.

With a 64-entry table, random destinations land on every table byte and every bit position within a few hundred frames. Directed single-bit tables therefore pin down the index mapping exactly.

The six-byte header is short enough that the tests can be fully controlled. Gaps can be placed at every header position, and restarts can be placed part-way through the header.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CRC_W    = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    // Receive configuration, sampled at the last header byte.
    typedef struct packed {
        logic promisc;
        logic bcast_en;
        logic mcast_en;
    } rx_cfg_t;

    // Classification of a destination address.
    typedef struct packed {
        logic unicast_hit;
        logic bcast;
        logic mcast;
        logic hash_hit;
    } addr_class_t;

    // One byte of CRC-32: bits fed least significant first, shifting left.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            fb = c[CRC_W-1] ^ data[b];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/da_filter_collect.sv
module da_filter_collect
    import da_filter_pkg::*;
#(
    parameter int unsigned N_BYTES = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        byte_vld,
    input  logic                        sof,
    input  logic [BYTE_W-1:0]           byte_data,
    output logic [N_BYTES*BYTE_W-1:0]   addr_now,
    output logic                        take,
    output logic                        last_byte
);

    localparam int unsigned CW = $clog2(N_BYTES + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic [N_BYTES*BYTE_W-1:0] addr_q;

    // cnt_q == N_BYTES means "header complete / waiting for sof".
    assign idx       = sof ? '0 : cnt_q;
    assign take      = byte_vld && (sof || (cnt_q < CW'(N_BYTES)));
    assign last_byte = take && (idx == CW'(N_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(N_BYTES);
        end else if (take) begin
            cnt_q <= idx + 1'b1;
        end
    end

    for (genvar i = 0; i < N_BYTES; i++) begin : g_lane
        logic hit;
        assign hit = take && (idx == CW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[i*BYTE_W +: BYTE_W] <= '0;
            end else if (hit) begin
                addr_q[i*BYTE_W +: BYTE_W] <= byte_data;
            end
        end

        // Merge the byte arriving this cycle so the last one is seen at once.
        assign addr_now[i*BYTE_W +: BYTE_W] = hit ? byte_data : addr_q[i*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/da_filter_hash.sv
module da_filter_hash
    import da_filter_pkg::*;
#(
    parameter int unsigned HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 sof,
    input  logic [BYTE_W-1:0]    byte_data,
    output logic [HASH_BITS-1:0] hash_idx
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_next;

    assign crc_base = sof ? CRC_INIT : crc_q;
    assign crc_next = crc_step_byte(crc_base, byte_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
        end else if (take) begin
            crc_q <= crc_next;
        end
    end

    assign hash_idx = crc_next[CRC_W-1 -: HASH_BITS];

endmodule

// File: rtl/da_filter_decide.sv
module da_filter_decide
    import da_filter_pkg::*;
#(
    parameter int unsigned N_BYTES   = 6,
    parameter int unsigned HASH_BITS = 6
) (
    input  logic [N_BYTES*BYTE_W-1:0] dest,
    input  logic [N_BYTES*BYTE_W-1:0] station,
    input  logic [(1<<HASH_BITS)-1:0] table_bits,
    input  logic [HASH_BITS-1:0]      hash_idx,
    input  rx_cfg_t                   cfg,
    output logic                      accept_now
);

    addr_class_t cls;

    always_comb begin
        cls.unicast_hit = (dest == station);
        cls.bcast       = &dest;
        cls.mcast       = dest[0] && !cls.bcast;
        cls.hash_hit    = table_bits[hash_idx];
    end

    always_comb begin
        accept_now = cfg.promisc
                  || cls.unicast_hit
                  || (cls.bcast && cfg.bcast_en)
                  || (cls.mcast && cfg.mcast_en && cls.hash_hit);
    end

endmodule

// File: rtl/da_filter.sv
module da_filter
    import da_filter_pkg::*;
#(
    parameter int unsigned N_BYTES   = 6,
    parameter int unsigned HASH_BITS = 6,
    localparam int unsigned ADDR_W   = N_BYTES * BYTE_W,
    localparam int unsigned TBL_W    = 1 << HASH_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic              sof,
    input  logic [7:0]        byte_data,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [TBL_W-1:0]  mcast_table,
    input  logic              cfg_bcast_en,
    input  logic              cfg_mcast_en,
    input  logic              cfg_promisc,
    output logic              accept,
    output logic              decision_vld
);

    logic [ADDR_W-1:0]    dest_now;
    logic                 take;
    logic                 last_byte;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 accept_now;
    rx_cfg_t              cfg;

    assign cfg = '{promisc: cfg_promisc, bcast_en: cfg_bcast_en, mcast_en: cfg_mcast_en};

    da_filter_collect #(.N_BYTES(N_BYTES)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .sof       (sof),
        .byte_data (byte_data),
        .addr_now  (dest_now),
        .take      (take),
        .last_byte (last_byte)
    );

    da_filter_hash #(.HASH_BITS(HASH_BITS)) u_hash (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .sof       (sof),
        .byte_data (byte_data),
        .hash_idx  (hash_idx)
    );

    da_filter_decide #(.N_BYTES(N_BYTES), .HASH_BITS(HASH_BITS)) u_decide (
        .dest       (dest_now),
        .station    (station_addr),
        .table_bits (mcast_table),
        .hash_idx   (hash_idx),
        .cfg        (cfg),
        .accept_now (accept_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept       <= 1'b0;
            decision_vld <= 1'b0;
        end else begin
            decision_vld <= last_byte;
            if (last_byte) begin
                accept <= accept_now;
            end else if (byte_vld && sof) begin
                accept <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/da_filter_checker.sv
module da_filter_checker (
    input logic clk,
    input logic rst,
    input logic byte_vld,
    input logic sof,
    input logic cfg_promisc,
    input logic accept,
    input logic decision_vld
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!accept && !decision_vld));

    a_r2_strobe_follows_byte: assert property (@(posedge clk) disable iff (rst)
        decision_vld |-> $past(byte_vld));

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        decision_vld |=> !decision_vld);

    a_r7_promisc_accepts: assert property (@(posedge clk) disable iff (rst)
        (decision_vld && $past(cfg_promisc)) |-> accept);

    a_r9_clear_on_sof: assert property (@(posedge clk) disable iff (rst)
        $past(byte_vld && sof) |-> !accept);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!decision_vld && !$past(byte_vld && sof)) |-> $stable(accept));

endmodule

bind da_filter da_filter_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_vld     (byte_vld),
    .sof          (sof),
    .cfg_promisc  (cfg_promisc),
    .accept       (accept),
    .decision_vld (decision_vld)
);

// File: tb/da_filter_tb.sv
module da_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic        sof = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [47:0] station_addr = 48'h0;
    logic [63:0] mcast_table = 64'h0;
    logic        cfg_bcast_en = 1'b0;
    logic        cfg_mcast_en = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic        accept;
    logic        decision_vld;

    int n_run  = 0;
    int n_fail = 0;
    int pulses = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    da_filter u_dut (
        .clk          (clk),
        .rst          (rst),
        .byte_vld     (byte_vld),
        .sof          (sof),
        .byte_data    (byte_data),
        .station_addr (station_addr),
        .mcast_table  (mcast_table),
        .cfg_bcast_en (cfg_bcast_en),
        .cfg_mcast_en (cfg_mcast_en),
        .cfg_promisc  (cfg_promisc),
        .accept       (accept),
        .decision_vld (decision_vld)
    );

    always @(posedge clk) if (decision_vld) pulses++;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] model_hash(input logic [47:0] da);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = r[31] ^ da[(i/8)*8 + (i%8)];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r[31:26];
    endfunction

    function automatic bit model_accept(input logic [47:0] da);
        bit bc = (da == 48'hFFFF_FFFF_FFFF);
        bit mc = da[0] && !bc;
        return cfg_promisc || (da == station_addr) || (bc && cfg_bcast_en)
            || (mc && cfg_mcast_en && mcast_table[model_hash(da)]);
    endfunction

    task automatic drive_byte(input logic [7:0] d, input bit s, input int gapmax);
        int g = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
        for (int k = 0; k < g; k++) begin
            byte_vld = 1'b0; sof = 1'b0;
            @(negedge clk);
        end
        byte_vld = 1'b1; sof = s; byte_data = d;
        @(negedge clk);
    endtask

    // Send one frame and check the decision, the hold and the strobe count.
    task automatic send_frame(input logic [47:0] da, input int extra, input int gapmax, input string req);
        bit exp = model_accept(da);
        pulses = 0;
        for (int i = 0; i < 6; i++) drive_byte(da[i*8 +: 8], i == 0, gapmax);
        byte_vld = 1'b0; sof = 1'b0;
        check(decision_vld === 1'b1, {req, " R2 strobe"}, 64'(decision_vld), 1);
        check(accept === exp, req, 64'(accept), 64'(exp));
        for (int i = 0; i < extra; i++) drive_byte(8'($urandom), 1'b0, gapmax);
        byte_vld = 1'b0;
        @(negedge clk);
        check(accept === exp, "R10 hold after payload", 64'(accept), 64'(exp));
        check(pulses == 1, "R2 one strobe per frame", 64'(pulses), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] da;
        logic [5:0]  h;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        check(accept === 1'b0 && decision_vld === 1'b0, "R1 during reset", {accept, decision_vld}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(accept === 1'b0 && decision_vld === 1'b0, "R1 after reset", {accept, decision_vld}, 0);

        // R10: bytes without sof after reset are ignored
        pulses = 0;
        for (int i = 0; i < 8; i++) drive_byte(8'hFF, 1'b0, 0);
        byte_vld = 1'b0;
        cfg_promisc = 1'b1;
        @(negedge clk); @(negedge clk);
        check(pulses == 0 && accept === 1'b0, "R10 no sof ignored", 64'(pulses), 0);
        cfg_promisc = 1'b0;

        station_addr = 48'h5544_3322_1100 | 48'h0000_0000_0002;
        send_frame(station_addr, 3, 0, "R3 unicast hit");
        send_frame(station_addr ^ 48'h0100_0000_0000, 2, 0, "R8 unicast miss last byte");
        send_frame(48'hFFFF_FFFF_FFFF, 1, 0, "R4 bcast disabled");
        cfg_bcast_en = 1'b1; mcast_table = '1; cfg_mcast_en = 1'b1;
        send_frame(48'hFFFF_FFFF_FFFF, 1, 0, "R4 bcast enabled");
        cfg_bcast_en = 1'b0;
        send_frame(48'hFFFF_FFFF_FFFF, 1, 0, "R4 bcast not multicast");

        da = 48'h0000_005E_0001;
        da[0] = 1'b1;
        h = model_hash(da);
        mcast_table = 64'h1 << h;
        send_frame(da, 2, 1, "R5 R6 single table bit");
        mcast_table = ~(64'h1 << h);
        send_frame(da, 2, 1, "R6 only hashed bit clear");
        mcast_table = '1; cfg_mcast_en = 1'b0;
        send_frame(da, 2, 1, "R5 mcast disabled");
        cfg_promisc = 1'b1;
        send_frame(48'h1234_5678_9ABC, 2, 3, "R7 promisc");
        cfg_promisc = 1'b0;

        // R11: restart part-way through a header
        for (int i = 0; i < 3; i++) drive_byte(station_addr[i*8 +: 8] ^ 8'h55, i == 0, 0);
        send_frame(station_addr, 0, 2, "R11 restart");

        // R12: config changed after the decision does not alter it
        send_frame(station_addr ^ 48'h10, 0, 0, "R8 reject");
        cfg_promisc = 1'b1;
        @(negedge clk);
        check(accept === 1'b0, "R12 config after decision", 64'(accept), 0);
        cfg_promisc = 1'b0;

        for (int n = 0; n < 400; n++) begin
            int kind = int'($urandom % 4);
            station_addr = {16'($urandom), $urandom()};
            mcast_table  = {$urandom(), $urandom()};
            cfg_bcast_en = 1'($urandom); cfg_mcast_en = 1'($urandom);
            cfg_promisc  = (($urandom % 8) == 0);
            case (kind)
                0: da = station_addr;
                1: da = 48'hFFFF_FFFF_FFFF;
                2: begin da = {16'($urandom), $urandom()}; da[0] = 1'b1; end
                default: begin da = {16'($urandom), $urandom()}; da[0] = 1'b0; end
            endcase
            send_frame(da, int'($urandom % 4), int'($urandom % 3), "R3 R4 R5 R8 random");
        end

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule